// File: doc/BRIEF.md
# Chained-Transfer SPI Master

This block is an SPI master that a host drives through one valid/ready command port carrying two kinds of command. A configuration command sets the flags, the transfer length in bits, the SCLK divider and the number of the select line for the transfers that follow. A data command starts one transfer with a left-aligned 32-bit word. Each transfer is one segment of a frame. The select line stays asserted from one segment to the next until a segment that carries the end flag finishes. Between segments the host may change the length, the divider and the receive option, so a frame can send a short command quickly and then read a long reply slowly.

A segment that carries the input flag stores its received bits, right-aligned, in a small readback FIFO. The FIFO is read through a valid/ready pair. Clock polarity, clock phase, bit order, select polarity and a half-duplex option are set for each segment. An offline flag disables all pin drivers and makes the block drop data commands without acting on them.

Top module: `chspi_master`

## Requirements
- R1: After reset the block accepts commands (`cmd_ready`=1), `rd_valid`=0, every select line is high (inactive, active-low by default), `sclk_o`=0 and all three output enables are 1.
- R2: The configuration word uses these fields: bit0 offline, bit1 end, bit2 input, bit3 select polarity, bit4 CPOL, bit5 CPHA, bit6 LSB-first, bit7 half-duplex, bits[13:8] length in bits (0 or above 32 means 32), bits[23:16] divider, bits[26:24] select number. A data word sends its upper L bits, bit 31 first, as L SCLK cycles.
- R3: A segment without the end flag leaves the select line asserted after it completes. A segment with the end flag releases the select line when it completes.
- R4: Each SCLK half-period lasts exactly N system clocks for a divider value N. Divider values below 2 act as 2.
- R5: While a transfer is in progress `cmd_ready` is 0, and any pending command waits until the transfer finishes.
- R6: A segment with the input flag pushes its L received bits into the FIFO right-aligned, the first bit in the highest of those positions and upper bits zero. A segment without the input flag pushes nothing.
- R7: When no transfer runs, SCLK rests at CPOL. With CPHA=0 the master samples on the leading edge. With CPHA=1 it samples on the trailing edge. In both cases the slave sees each MOSI bit stable at its sampling edge.
- R8: With LSB-first set, the L-bit field is sent starting from bit 32-L, and the received bits are stored with the first bit at position 0.
- R9: Only the select line named by the select number ever goes active. Polarity 1 makes the active level high. Polarity 0 makes it low.
- R10: In a half-duplex input segment, `mosi_oe` is 0 during the transfer and the received bits come from `mosi_i` instead of `miso_i`.
- R11: With the offline flag set, all output enables are 0, and data commands are accepted but start no transfer and push nothing.
- R12: A data command with the input flag is held off (`cmd_ready`=0) while the readback FIFO is full, and it starts once an entry has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken on this clock edge if valid |
| cmd_is_cfg | input | 1 | 1 = configuration command, 0 = data command |
| cmd_data | input | 32 | Configuration word or left-aligned transmit data |
| rd_valid | output | 1 | Readback FIFO holds a word |
| rd_ready | input | 1 | Host takes the readback word |
| rd_data | output | 32 | Oldest received word, right-aligned |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock driver enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out driver enable |
| mosi_i | input | 1 | Data line read back for half-duplex receive |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NCS | Select lines |
| cs_oe | output | 1 | Select line driver enable |

## Verification
The hardest situation to reach from the ports is a data command that stalls only because the readback FIFO is full, while the configuration and the bus are otherwise idle. The bench holds `rd_ready` low through four back-to-back input segments so that the FIFO fills. It then presents a fifth input command and watches `cmd_ready` stay low for many cycles. Finally it releases `rd_ready` and checks that all five words drain in order. A slave model counts SCLK rising edges within each frame and serves bits from a fixed pattern. Because the count continues across segments, this also checks that a multi-segment frame with mixed dividers keeps one select assertion.

// File: rtl/chspi_pkg.sv
package chspi_pkg;
   localparam int WORD_W = 32;
   localparam int LEN_W  = 6;
   localparam int DIV_W  = 8;
   localparam int SEL_W  = 3;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic [DIV_W-1:0] div;
      logic [LEN_W-1:0] len;
      logic             half_duplex;
      logic             lsb_first;
      logic             cpha;
      logic             cpol;
      logic             cs_pol;
      logic             inp;
      logic             last;
      logic             offline;
   } cfg_t;

   function automatic cfg_t decode_cfg(input logic [WORD_W-1:0] w);
      cfg_t d;
      d.offline     = w[0];
      d.last        = w[1];
      d.inp         = w[2];
      d.cs_pol      = w[3];
      d.cpol        = w[4];
      d.cpha        = w[5];
      d.lsb_first   = w[6];
      d.half_duplex = w[7];
      d.len         = w[8 +: LEN_W];
      d.div         = w[16 +: DIV_W];
      d.sel         = w[24 +: SEL_W];
      return d;
   endfunction

   function automatic logic [WORD_W-1:0] rev_word(input logic [WORD_W-1:0] w);
      logic [WORD_W-1:0] r;
      for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
      return r;
   endfunction
endpackage

// File: rtl/chspi_clkdiv.sv
module chspi_clkdiv #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] half,
   output logic         tick
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || cnt_q == '0) cnt_q <= half - W'(1);
      else                       cnt_q <= cnt_q - W'(1);
   end

   assign tick = run && (cnt_q == '0);

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R4
endmodule

// File: rtl/chspi_shifter.sv
module chspi_shifter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift_en,
   input  logic         sample_en,
   input  logic         rx_bit,
   output logic         tx_bit,
   output logic [W-1:0] rx_word
);
   logic [W-1:0] tx_q, rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else if (load) begin
         tx_q <= load_val;
         rx_q <= '0;
      end else begin
         if (shift_en)  tx_q <= {tx_q[W-2:0], 1'b0};
         if (sample_en) rx_q <= {rx_q[W-2:0], rx_bit};
      end
   end

   assign tx_bit  = tx_q[W-1];
   assign rx_word = rx_q;
endmodule

// File: rtl/chspi_csdec.sv
module chspi_csdec #(
   parameter int NCS   = 4,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             pol,
   input  logic [SEL_W-1:0] sel,
   output logic [NCS-1:0]   cs
);
   for (genvar g = 0; g < NCS; g++) begin : g_line
      assign cs[g] = (act && sel == SEL_W'(g)) ? pol : ~pol;
   end

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cs ^ {NCS{~pol}}) <= 1); // R9
endmodule

// File: rtl/chspi_rdfifo.sv
module chspi_rdfifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp_q, rp_q;

   initial begin : p_param
      assert (DEPTH >= 2 && (1 << AW) == DEPTH) else $error("DEPTH must be a power of two >= 2");
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp_q[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   assign empty = (wp_q == rp_q);
   assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign dout  = mem[rp_q[AW-1:0]];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R12
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R6
endmodule

// File: rtl/chspi_master.sv
module chspi_master
   import chspi_pkg::*;
#(
   parameter int NCS        = 4,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_is_cfg,
   input  logic [WORD_W-1:0] cmd_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [WORD_W-1:0] rd_data,
   output logic              sclk_o,
   output logic              sclk_oe,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              mosi_i,
   input  logic              miso_i,
   output logic [NCS-1:0]    cs_o,
   output logic              cs_oe
);
   localparam int EDGE_W = LEN_W + 1;

   initial begin : p_param
      assert (NCS >= 1 && NCS <= (1 << SEL_W)) else $error("NCS out of range");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} st_t;

   st_t               st_q;
   cfg_t              cfg_q;
   logic              cs_act_q, lvl_q;
   logic [EDGE_W-1:0] edge_q;

   logic [LEN_W-1:0]  len_eff, shamt;
   logic [DIV_W-1:0]  half_eff;
   logic [EDGE_W-1:0] last_edge;
   logic              tick, fifo_full, fifo_empty;
   logic              data_go, cfg_go, leading, sample_en, shift_en, push;
   logic              rx_bit, tx_bit;
   logic [WORD_W-1:0] tx_load, rx_word, push_val;

   // ---------------- segment parameters ----------------
   assign len_eff   = (cfg_q.len == '0 || cfg_q.len > LEN_W'(WORD_W)) ? LEN_W'(WORD_W) : cfg_q.len;
   assign shamt     = LEN_W'(WORD_W) - len_eff;
   assign half_eff  = (cfg_q.div < DIV_W'(2)) ? DIV_W'(2) : cfg_q.div;
   assign last_edge = {len_eff, 1'b0} - EDGE_W'(1);

   // ---------------- command port ----------------
   assign cmd_ready = (st_q == ST_IDLE) &&
                      (cmd_is_cfg || cfg_q.offline || !cfg_q.inp || !fifo_full);
   assign data_go   = cmd_valid && cmd_ready && !cmd_is_cfg && !cfg_q.offline;
   assign cfg_go    = cmd_valid && cmd_ready && cmd_is_cfg;

   assign tx_load   = cfg_q.lsb_first ? (rev_word(cmd_data) << shamt) : cmd_data;

   // ---------------- edge scheduling ----------------
   assign leading   = ~edge_q[0];
   assign sample_en = (st_q == ST_RUN) && tick && (leading ^ cfg_q.cpha);
   assign shift_en  = (st_q == ST_RUN) && tick &&
                      (cfg_q.cpha ? (leading && edge_q != '0) : !leading);
   assign rx_bit    = cfg_q.half_duplex ? mosi_i : miso_i;
   assign push      = (st_q == ST_TAIL) && tick && cfg_q.inp;
   assign push_val  = cfg_q.lsb_first ? (rev_word(rx_word) >> shamt) : rx_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cfg_q    <= '0;
         cs_act_q <= 1'b0;
         lvl_q    <= 1'b0;
         edge_q   <= '0;
      end else begin
         if (cfg_go) cfg_q <= decode_cfg(cmd_data);
         unique case (st_q)
            ST_IDLE: if (data_go) begin
               st_q     <= ST_RUN;
               cs_act_q <= 1'b1;
               lvl_q    <= 1'b0;
               edge_q   <= '0;
            end
            ST_RUN: if (tick) begin
               lvl_q  <= ~lvl_q;
               edge_q <= edge_q + EDGE_W'(1);
               if (edge_q == last_edge) st_q <= ST_TAIL;
            end
            ST_TAIL: if (tick) begin
               st_q <= ST_IDLE;
               if (cfg_q.last) cs_act_q <= 1'b0;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- sub-blocks ----------------
   chspi_clkdiv #(.W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(st_q != ST_IDLE), .half(half_eff), .tick(tick));

   chspi_shifter #(.W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(data_go), .load_val(tx_load),
      .shift_en(shift_en), .sample_en(sample_en), .rx_bit(rx_bit),
      .tx_bit(tx_bit), .rx_word(rx_word));

   chspi_csdec #(.NCS(NCS), .SEL_W(SEL_W)) u_cs (
      .clk(clk), .rst_n(rst_n), .act(cs_act_q), .pol(cfg_q.cs_pol),
      .sel(cfg_q.sel), .cs(cs_o));

   chspi_rdfifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(push_val),
      .pop(rd_valid && rd_ready), .dout(rd_data), .full(fifo_full), .empty(fifo_empty));

   // ---------------- pins ----------------
   assign rd_valid = !fifo_empty;
   assign sclk_o   = cfg_q.cpol ^ lvl_q;
   assign mosi_o   = tx_bit;
   assign sclk_oe  = !cfg_q.offline;
   assign cs_oe    = !cfg_q.offline;
   assign mosi_oe  = !cfg_q.offline &&
                     !(st_q != ST_IDLE && cfg_q.half_duplex && cfg_q.inp);

   // ---------------- assertions ----------------
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      data_go |=> !cmd_ready); // R5
   AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> (sclk_o == cfg_q.cpol)); // R7
   AST_OFFLINE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && !cmd_is_cfg && cfg_q.offline) |=> (st_q == ST_IDLE)); // R11
   AST_FRAME_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TAIL && tick && !cfg_q.last) |=> cs_act_q); // R3
   AST_HD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && cfg_q.half_duplex && cfg_q.inp) |-> !mosi_oe); // R10
endmodule

// File: tb/chspi_master_bench.sv
module chspi_master_bench;
   localparam int NCS = 4;
   localparam logic [127:0] PAT = 128'hC3A5_96E1_0F7B_2D48_B1E6_7C09_5A3F_D284;
   localparam logic [7:0] F_OFF = 8'h01, F_END = 8'h02, F_INP = 8'h04, F_POL = 8'h08,
                          F_CPOL = 8'h10, F_CPHA = 8'h20, F_LSB = 8'h40, F_HD = 8'h80;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_is_cfg = 1'b1, rd_ready = 1'b1;
   logic [31:0] cmd_data = '0;
   logic cmd_ready, rd_valid, sclk_o, sclk_oe, mosi_o, mosi_oe, cs_oe, miso_i, mosi_i;
   logic [31:0] rd_data;
   logic [NCS-1:0] cs_o;

   int errors = 0, checks = 0;
   logic [7:0] c_flags = 8'h00;
   int c_len = 32;

   logic [127:0] q_fb[$];
   int           q_fn[$];
   logic [31:0]  q_rd[$];
   logic [127:0] exp_bits = '0, acc = '0;
   int           exp_n = 0, mon_n = 0;
   logic [6:0]   rcnt = '0;
   logic         act_prev = 1'b0, sclk_prev = 1'b0, act;

   always #2.5 clk = ~clk;

   chspi_master #(.NCS(NCS), .FIFO_DEPTH(4)) u_chspi_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_is_cfg(cmd_is_cfg), .cmd_data(cmd_data), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .rd_data(rd_data), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_i(miso_i),
      .cs_o(cs_o), .cs_oe(cs_oe));

   assign miso_i = PAT[7'd127 - rcnt];
   assign mosi_i = ~miso_i;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act_v, input logic [127:0] exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   // ---------------- monitor: slave model and scoreboard ----------------
   always @(negedge clk) begin
      act = cs_oe && ((cs_o ^ {NCS{~c_flags[3]}}) != '0);
      if (act && !act_prev) begin acc = '0; mon_n = 0; rcnt = '0; end
      if (act && sclk_o && !sclk_prev) begin
         acc = {acc[126:0], mosi_o & mosi_oe};
         mon_n++;
         rcnt = rcnt + 7'd1;
      end
      if (!act && act_prev) begin
         if (q_fb.size() == 0) chk(0, "R2 unexpected frame", acc, 0);
         else begin
            logic [127:0] eb; int en;
            eb = q_fb.pop_front(); en = q_fn.pop_front();
            chk(acc == eb && mon_n == en, "R2/R3 frame bits", acc, eb);
         end
      end
      if (!act) rcnt = '0;
      act_prev  = act;
      sclk_prev = sclk_o;
      if (rd_valid && rd_ready) begin
         if (q_rd.size() == 0) chk(0, "R6 unexpected readback", rd_data, 0);
         else begin
            logic [31:0] er;
            er = q_rd.pop_front();
            chk(rd_data == er, "R6 readback word", rd_data, er);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic issue(input logic is_cfg, input logic [31:0] w);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_is_cfg = is_cfg; cmd_data = w;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      @(posedge clk); #1;
      cmd_valid = 1'b0; cmd_is_cfg = 1'b1;
   endtask

   task automatic set_cfg(input logic [7:0] fl, input int len, input int dv, input int sel);
      issue(1'b1, {5'd0, 3'(sel), 8'(dv), 2'd0, 6'(len), fl});
      c_flags = fl;
      c_len   = (len == 0 || len > 32) ? 32 : len;
   endtask

   task automatic expect_data(input logic [31:0] d);
      logic [31:0] r;
      logic b;
      if (c_flags[0]) return;
      r = '0;
      for (int i = 0; i < c_len; i++) begin
         if (c_flags[2]) begin
            b = PAT[127 - (exp_n + i)];
            if (c_flags[7]) b = ~b;
            if (c_flags[6]) r[i] = b;
            else            r = {r[30:0], b};
         end
      end
      for (int i = 0; i < c_len; i++) begin
         b = c_flags[6] ? d[32 - c_len + i] : d[31 - i];
         if (c_flags[7] && c_flags[2]) b = 1'b0;
         exp_bits = {exp_bits[126:0], b};
         exp_n++;
      end
      if (c_flags[2]) q_rd.push_back(r);
      if (c_flags[1]) begin
         q_fb.push_back(exp_bits); q_fn.push_back(exp_n);
         exp_bits = '0; exp_n = 0;
      end
   endtask

   task automatic send(input logic [31:0] d);
      expect_data(d);
      issue(1'b0, d);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic measure_half(input int n, input string tag);
      logic lv;
      int cnt;
      @(negedge clk);
      while (sclk_o == c_flags[4]) @(negedge clk);
      lv = sclk_o; cnt = 0;
      do begin @(negedge clk); cnt++; end while (sclk_o == lv && cnt < 100);
      chk(cnt == n, tag, cnt, n);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready && !rd_valid && cs_o == 4'hF && !sclk_o && sclk_oe && mosi_oe && cs_oe,
          "R1 reset state", {cmd_ready, rd_valid, cs_o, sclk_o}, {1'b1, 1'b0, 4'hF, 1'b0});

      // R2 R9: single 8-bit segment on line 0
      set_cfg(F_END, 8, 2, 0);
      send(32'hA5F0_0F00);
      @(negedge clk);
      chk(!cmd_ready, "R5 busy hold-off", cmd_ready, 0);
      chk(cs_o == 4'b1110, "R9 line 0 active low", cs_o, 4'b1110);
      wait_idle();

      // R3: three-segment frame, changing divider and length mid-frame
      set_cfg(8'h00, 16, 2, 1);
      send(32'h1234_0000);
      wait_idle();
      chk(cs_o == 4'b1101, "R3 select held between segments", cs_o, 4'b1101);
      set_cfg(F_INP, 24, 16, 1);
      send(32'h9ABC_DE00);
      wait_idle();
      set_cfg(F_END | F_INP, 8, 3, 1);
      send(32'h5600_0000);
      wait_idle();
      chk(cs_o == 4'b1111, "R3 select released after end", cs_o, 4'b1111);

      // R4: divider half-periods, minimum clamp
      set_cfg(F_END, 8, 5, 0);
      send(32'hC300_0000);
      measure_half(5, "R4 half period div 5");
      wait_idle();
      set_cfg(F_END, 8, 0, 0);
      send(32'h3C00_0000);
      measure_half(2, "R4 divider 0 clamps to 2");
      wait_idle();
      set_cfg(F_END | F_INP, 8, 16, 0);
      send(32'h7E00_0000);
      measure_half(16, "R4 half period div 16");
      wait_idle();

      // R7: mode 3
      set_cfg(F_END | F_CPOL | F_CPHA | F_INP, 16, 3, 2);
      @(negedge clk);
      chk(sclk_o == 1'b1, "R7 idle level follows CPOL", sclk_o, 1);
      send(32'hBEEF_0000);
      wait_idle();

      // R8: LSB-first, 12 bits
      set_cfg(F_END | F_LSB | F_INP, 12, 2, 0);
      send(32'hABC0_0000);
      wait_idle();

      // R9: active-high polarity on line 3
      set_cfg(F_END | F_POL, 8, 2, 3);
      @(negedge clk);
      chk(cs_o == 4'b0000, "R9 idle with active-high polarity", cs_o, 0);
      send(32'h8100_0000);
      @(negedge clk);
      chk(cs_o == 4'b1000, "R9 line 3 active high", cs_o, 4'b1000);
      wait_idle();

      // R10: half-duplex receive
      set_cfg(F_END | F_HD | F_INP, 8, 4, 0);
      send(32'hFF00_0000);
      @(negedge clk);
      chk(mosi_oe == 1'b0, "R10 data line released", mosi_oe, 0);
      wait_idle();

      // R6: 32-bit write-only segment pushes nothing
      set_cfg(F_END, 32, 2, 0);
      send(32'h8000_0001);
      wait_idle();
      repeat (3) @(negedge clk);
      chk(!rd_valid, "R6 no push without input flag", rd_valid, 0);

      // R12: FIFO full hold-off
      rd_ready = 1'b0;
      set_cfg(F_END | F_INP, 8, 2, 0);
      for (int k = 0; k < 4; k++) begin
         send(32'(k + 1) << 24);
         wait_idle();
      end
      expect_data(32'h5500_0000);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_is_cfg = 1'b0; cmd_data = 32'h5500_0000;
      repeat (20) @(negedge clk);
      chk(!cmd_ready, "R12 held off while FIFO full", cmd_ready, 0);
      chk(rd_valid, "R12 FIFO holds data", rd_valid, 1);
      @(posedge clk); #1 rd_ready = 1'b1;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      @(posedge clk); #1;
      cmd_valid = 1'b0; cmd_is_cfg = 1'b1;
      wait_idle();
      repeat (6) @(negedge clk);

      // R11: offline
      set_cfg(F_OFF | F_INP, 8, 2, 0);
      @(negedge clk);
      chk(!sclk_oe && !mosi_oe && !cs_oe, "R11 drivers disabled", {sclk_oe, mosi_oe, cs_oe}, 0);
      send(32'hF0F0_0000);
      @(negedge clk);
      chk(cmd_ready, "R11 data write dropped", cmd_ready, 1);
      repeat (40) @(negedge clk);
      chk(!rd_valid && sclk_o == 1'b0, "R11 no activity", {rd_valid, sclk_o}, 0);
      set_cfg(F_END, 8, 2, 0);
      @(negedge clk);
      chk(sclk_oe && mosi_oe && cs_oe, "R11 drivers back online", {sclk_oe, mosi_oe, cs_oe}, 3'b111);

      repeat (10) @(negedge clk);
      chk(q_fb.size() == 0, "R3 all frames seen", q_fb.size(), 0);
      chk(q_rd.size() == 0, "R6 all readbacks seen", q_rd.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule